// File: doc/BRIEF.md
# Double-Buffered Frame Store with Exposure Timestamps

This block sits beside a line-sensor readout sequencer and holds two pixel banks. While a capture runs, incoming pixels go into the active bank. A consumer reads the other bank, which holds the most recent finished frame. Each capture start swaps the roles of the two banks. A request to start that arrives while a capture is still running is held and is served as soon as that capture completes.

The block runs its own microsecond counter. When a capture is accepted, it stamps the bank about to be filled with the midpoint of that frame's exposure window. The window opens at an estimated integration start and closes at the moment of acceptance. The estimated start is a fixed lead after the previous acceptance, or a shorter lead after a flush of the sensor array. The consumer reads the stamp together with the pixel data.

The block also keeps a 64-bit sum of scan durations and a 32-bit count of finished scans. A sequential divider derives the mean scan time from these two values.

Top module: `fbuf_pingpong`

## Requirements
- R1: After reset, `wr_bank` is 0, `cap_busy` is 0, `now_us`, `stat_total`, `stat_runs` and `stat_avg` are all 0, and `rd_stamp` reads 0.
- R2: `now_us` increases by exactly one every `CLK_PER_US` clock cycles and wraps modulo 2^32.
- R3: A `cap_start` pulse while idle is accepted: `cap_accept` is high in that cycle, and on the next edge `wr_bank` inverts and `cap_busy` rises. Bank 0 and bank 1 are selected by `wr_bank` = 0 and 1. The read side always uses bank `!wr_bank`.
- R4: A `cap_start` pulse while `cap_busy` is high does not change `wr_bank`. It is remembered, and it is accepted in the cycle after the completion that clears `cap_busy`.
- R5: At acceptance, with current time T and integration estimate I, the bank being filled gets the stamp I + ((T − I) mod 2^32)/2 (integer division, all modulo 2^32). I then becomes T + `INT_LEAD_US` (default 38).
- R6: A `flush` pulse sets the integration estimate to the current time plus `FLUSH_LEAD_US` (default 2). A capture accepted in the same cycle takes priority.
- R7: A `cap_done` pulse while busy adds (T − T0) mod 2^32 to `stat_total`, where T0 is the acceptance time, increments `stat_runs` and clears `cap_busy`. A `cap_done` pulse while idle changes nothing.
- R8: `stat_avg` is the low 32 bits of `stat_total`/`stat_runs` and is valid within 70 cycles of a completion. It is 0 while `stat_runs` is 0.
- R9: `wr_en` writes `wr_data` at `wr_addr` into the active bank only while `cap_busy` is high. Writes while idle are dropped.
- R10: `rd_data` and `rd_stamp` appear one cycle after `rd_addr`. Both are taken from the same stable bank in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_start | input | 1 | Request to begin a capture (pulse) |
| cap_done | input | 1 | Capture finished (pulse) |
| flush | input | 1 | Sensor array flush began (pulse) |
| cap_accept | output | 1 | Start is taken in this cycle |
| cap_busy | output | 1 | A capture is in progress |
| wr_bank | output | 1 | Index of the bank being filled |
| wr_en | input | 1 | Pixel write strobe |
| wr_addr | input | clog2(NPIX) | Pixel index to write |
| wr_data | input | PIX_W | Pixel value |
| rd_addr | input | clog2(NPIX) | Pixel index to read from the stable bank |
| rd_data | output | PIX_W | Pixel value, one cycle after rd_addr |
| rd_stamp | output | 32 | Exposure midpoint of the stable bank, in microseconds |
| now_us | output | 32 | Free-running microsecond time |
| stat_total | output | 64 | Sum of scan durations, in microseconds |
| stat_runs | output | 32 | Number of finished scans |
| stat_avg | output | 32 | Mean scan duration, in microseconds |

## Verification
A wrong bank selector shows up at the next read as pixel data from the wrong frame, and `rd_stamp` shows the stamp of the other bank one cycle after the read address. A corrupted integration estimate or acceptance time stays hidden until a later point. A bad estimate appears as a wrong stamp only after the following capture start, when that bank becomes the stable one. A bad acceptance time appears immediately in `stat_total` at the next completion. A divider fault shows up as a wrong `stat_avg` about 66 cycles after a completion.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int unsigned US_W   = 32;
  localparam int unsigned SUM_W  = 64;
  localparam int unsigned RUNS_W = 32;

  typedef logic [US_W-1:0] us_t;

  // Midpoint of an exposure window, all modulo 2^32.
  function automatic us_t mid_stamp(input us_t t_open, input us_t t_close);
    us_t span;
    span = t_close - t_open;
    return t_open + (span >> 1);
  endfunction

  // Elapsed microseconds, wrapping naturally.
  function automatic us_t elapsed_us(input us_t t_now, input us_t t_begin);
    return t_now - t_begin;
  endfunction
endpackage

// File: rtl/fbuf_us_timer.sv
module fbuf_us_timer #(
  parameter int unsigned CLK_PER_US = 250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 us_tick,
  output fbuf_pkg::us_t        now_us
);
  localparam int unsigned PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;

  assign us_tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      now_us <= '0;
    end else if (us_tick) begin
      pre_q  <= '0;
      now_us <= now_us + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/fbuf_stamp_ctrl.sv
module fbuf_stamp_ctrl
  import fbuf_pkg::*;
#(
  parameter int unsigned INT_LEAD_US   = 38,
  parameter int unsigned FLUSH_LEAD_US = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_start,
  input  logic                cap_done,
  input  logic                flush,
  input  us_t                 now_us,
  output logic                accept,
  output logic                done_evt,
  output logic                busy,
  output logic                bank,
  output us_t [1:0]           stamps,
  output us_t                 t0_us,
  output logic [SUM_W-1:0]    total,
  output logic [RUNS_W-1:0]   runs
);
  localparam us_t INT_LEAD   = US_W'(INT_LEAD_US);
  localparam us_t FLUSH_LEAD = US_W'(FLUSH_LEAD_US);

  logic pend_q;
  us_t  t_int_q;

  assign accept   = (cap_start | pend_q) & ~busy;
  assign done_evt = cap_done & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank    <= 1'b0;
      busy    <= 1'b0;
      pend_q  <= 1'b0;
      t_int_q <= '0;
      t0_us   <= '0;
      stamps  <= '0;
      total   <= '0;
      runs    <= '0;
    end else if (accept) begin
      bank          <= ~bank;
      busy          <= 1'b1;
      pend_q        <= 1'b0;
      t0_us         <= now_us;
      stamps[~bank] <= mid_stamp(t_int_q, now_us);
      t_int_q       <= now_us + INT_LEAD;
    end else begin
      if (done_evt) begin
        busy  <= 1'b0;
        total <= total + SUM_W'(elapsed_us(now_us, t0_us));
        runs  <= runs + 1'b1;
      end
      if (cap_start && busy) pend_q <= 1'b1;
      if (flush) t_int_q <= now_us + FLUSH_LEAD;
    end
  end
endmodule

// File: rtl/fbuf_avg_div.sv
module fbuf_avg_div #(
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [DEN_W-1:0] avg
);
  localparam int unsigned CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W:0]   rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;

  logic [DEN_W:0]   rem_sh;
  logic             fits;
  logic [NUM_W-1:0] quo_nx;
  logic [DEN_W:0]   rem_nx;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    fits   = (rem_sh >= {1'b0, den_q});
    quo_nx = {quo_q[NUM_W-2:0], fits};
    rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      avg   <= '0;
    end else if (go) begin
      quo_q <= num;
      rem_q <= '0;
      den_q <= den;
      cnt_q <= CW'(NUM_W);
      run_q <= (den != '0);
      if (den == '0) avg <= '0;
    end else if (run_q) begin
      quo_q <= quo_nx;
      rem_q <= rem_nx;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q <= 1'b0;
        avg   <= quo_nx[DEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/fbuf_bank_store.sv
module fbuf_bank_store #(
  parameter int unsigned NPIX  = 1280,
  parameter int unsigned PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     wsel,
  input  logic [$clog2(NPIX)-1:0]  waddr,
  input  logic [PIX_W-1:0]         wdata,
  input  logic                     rsel,
  input  logic [$clog2(NPIX)-1:0]  raddr,
  output logic [PIX_W-1:0]         rdata
);
  localparam int unsigned AW = $clog2(NPIX);

  logic [1:0][PIX_W-1:0] bank_q;
  logic                  rsel_q;
  logic                  waddr_ok;

  assign waddr_ok = (32'(waddr) < NPIX);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0] mem [NPIX];
    logic [PIX_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && waddr_ok && (wsel == b[0])) mem[waddr] <= wdata;
      if (32'(raddr) < NPIX) q <= mem[raddr];
      else q <= '0;
    end
    assign bank_q[b] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsel_q <= 1'b0;
    else        rsel_q <= rsel;
  end

  assign rdata = bank_q[rsel_q];

  logic unused_aw;
  assign unused_aw = (AW == 0);
endmodule

// File: rtl/fbuf_pingpong.sv
module fbuf_pingpong
  import fbuf_pkg::*;
#(
  parameter int unsigned NPIX          = 1280,
  parameter int unsigned PIX_W         = 8,
  parameter int unsigned CLK_PER_US    = 250,
  parameter int unsigned INT_LEAD_US   = 38,
  parameter int unsigned FLUSH_LEAD_US = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_start,
  input  logic                    cap_done,
  input  logic                    flush,
  output logic                    cap_accept,
  output logic                    cap_busy,
  output logic                    wr_bank,
  input  logic                    wr_en,
  input  logic [$clog2(NPIX)-1:0] wr_addr,
  input  logic [PIX_W-1:0]        wr_data,
  input  logic [$clog2(NPIX)-1:0] rd_addr,
  output logic [PIX_W-1:0]        rd_data,
  output logic [31:0]             rd_stamp,
  output logic [31:0]             now_us,
  output logic [63:0]             stat_total,
  output logic [31:0]             stat_runs,
  output logic [31:0]             stat_avg
);
  us_t       [1:0] stamps;
  us_t             t0_us;
  logic            done_evt;
  logic            us_tick;
  logic            div_go;
  logic            bank_we;

  fbuf_us_timer #(.CLK_PER_US(CLK_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .now_us(now_us)
  );

  fbuf_stamp_ctrl #(
    .INT_LEAD_US(INT_LEAD_US), .FLUSH_LEAD_US(FLUSH_LEAD_US)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .cap_done(cap_done),
    .flush(flush), .now_us(now_us), .accept(cap_accept), .done_evt(done_evt),
    .busy(cap_busy), .bank(wr_bank), .stamps(stamps), .t0_us(t0_us),
    .total(stat_total), .runs(stat_runs)
  );

  assign bank_we = wr_en & cap_busy;

  fbuf_bank_store #(.NPIX(NPIX), .PIX_W(PIX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wsel(wr_bank), .waddr(wr_addr),
    .wdata(wr_data), .rsel(~wr_bank), .raddr(rd_addr), .rdata(rd_data)
  );

  // Stamp is registered on the same edge and with the same selector as data.
  always_ff @(posedge clk) begin
    if (!rst_n) rd_stamp <= '0;
    else        rd_stamp <= stamps[~wr_bank];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) div_go <= 1'b0;
    else        div_go <= done_evt;
  end

  fbuf_avg_div #(.NUM_W(SUM_W), .DEN_W(RUNS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(stat_total),
    .den(stat_runs), .avg(stat_avg)
  );

  logic unused_tick;
  assign unused_tick = us_tick;
endmodule

// File: rtl/fbuf_pingpong_chk.sv
module fbuf_pingpong_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        done_evt,
  input logic        busy,
  input logic        bank,
  input logic [31:0] now_us,
  input logic [31:0] t0_us,
  input logic [63:0] total,
  input logic [31:0] runs,
  input logic [31:0] avg
);
  a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (now_us == $past(now_us)) || (now_us == $past(now_us) + 32'd1));

  a_r3_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (bank != $past(bank)));

  a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  a_r7_runs_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (runs == $past(runs) + 32'd1));

  a_r7_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (total == $past(total) + 64'($past(now_us) - $past(t0_us))));

  a_r8_zero_avg: assert property (@(posedge clk) disable iff (!rst_n)
    (runs == 32'd0) |-> (avg == 32'd0));
endmodule

bind fbuf_pingpong fbuf_pingpong_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(cap_accept), .done_evt(done_evt),
  .busy(cap_busy), .bank(wr_bank), .now_us(now_us), .t0_us(t0_us),
  .total(stat_total), .runs(stat_runs), .avg(stat_avg)
);

// File: tb/fbuf_pingpong_tb_top.sv
module fbuf_pingpong_tb_top;
  localparam int NPIX = 8;
  localparam int PIX_W = 8;
  localparam int CPU = 4;
  localparam int AW = $clog2(NPIX);
  localparam int NVEC = 6;
  // gap cycles, busy cycles, flush before start
  localparam int VEC [NVEC][3] = '{
    '{5, 300, 0}, '{3, 120, 1}, '{20, 40, 0},
    '{2, 600, 1}, '{10, 200, 0}, '{1, 80, 0}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cap_start, cap_done, flush, wr_en;
  logic cap_accept, cap_busy, wr_bank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PIX_W-1:0] wr_data, rd_data;
  logic [31:0] rd_stamp, now_us, stat_runs, stat_avg;
  logic [63:0] stat_total;

  fbuf_pingpong #(.NPIX(NPIX), .PIX_W(PIX_W), .CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .cap_done(cap_done),
    .flush(flush), .cap_accept(cap_accept), .cap_busy(cap_busy),
    .wr_bank(wr_bank), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_stamp(rd_stamp),
    .now_us(now_us), .stat_total(stat_total), .stat_runs(stat_runs),
    .stat_avg(stat_avg)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] tint_m, t0_m;
  logic [31:0] stamp_m [2];
  logic        sel_m;
  logic [63:0] total_m;
  logic [31:0] runs_m;
  logic [PIX_W-1:0] mem_m [2][NPIX];
  bit          filled_m [2];

  task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_mid(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = b - a;
    return a + d / 2;
  endfunction

  task automatic model_accept(input logic [31:0] t);
    sel_m = ~sel_m;
    stamp_m[sel_m] = model_mid(tint_m, t);
    t0_m = t;
    tint_m = t + 32'd38;
  endtask

  task automatic do_start();
    cap_start = 1'b1;
    model_accept(now_us);
    @(negedge clk);
    cap_start = 1'b0;
    expect_eq("R3 wr_bank after start", 64'(wr_bank), 64'(sel_m));
    expect_eq("R3 busy after start", 64'(cap_busy), 64'd1);
  endtask

  task automatic model_done(input logic [31:0] t);
    total_m = total_m + 64'(t - t0_m);
    runs_m = runs_m + 32'd1;
  endtask

  task automatic do_done();
    cap_done = 1'b1;
    model_done(now_us);
    @(negedge clk);
    cap_done = 1'b0;
    expect_eq("R7 busy cleared", 64'(cap_busy), 64'd0);
    expect_eq("R7 run count", 64'(stat_runs), 64'(runs_m));
    expect_eq("R7 total time", stat_total, total_m);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    tint_m = now_us + 32'd2;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic write_frame(input int id);
    for (int k = 0; k < NPIX; k++) begin
      wr_en = 1'b1;
      wr_addr = AW'(k);
      wr_data = PIX_W'(id * 37 + k * 11 + 5);
      if (cap_busy) mem_m[sel_m][k] = wr_data;
      @(negedge clk);
    end
    wr_en = 1'b0;
    if (cap_busy) filled_m[sel_m] = 1'b1;
  endtask

  task automatic check_frame();
    for (int k = 0; k < NPIX; k++) begin
      rd_addr = AW'(k);
      @(negedge clk);
      if (filled_m[~sel_m])
        expect_eq("R10 stable bank pixel", 64'(rd_data), 64'(mem_m[~sel_m][k]));
      expect_eq("R5 R10 stable bank stamp", 64'(rd_stamp), 64'(stamp_m[~sel_m]));
    end
  endtask

  task automatic check_avg();
    repeat (80) @(negedge clk);
    expect_eq("R8 mean scan time", 64'(stat_avg), 64'(32'(total_m / 64'(runs_m))));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] n0;
    rst_n = 1'b0; cap_start = 1'b0; cap_done = 1'b0; flush = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    tint_m = '0; t0_m = '0; stamp_m[0] = '0; stamp_m[1] = '0; sel_m = 1'b0;
    total_m = '0; runs_m = '0; filled_m[0] = 1'b0; filled_m[1] = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    expect_eq("R1 wr_bank", 64'(wr_bank), 64'd0);
    expect_eq("R1 busy", 64'(cap_busy), 64'd0);
    expect_eq("R1 now_us", 64'(now_us), 64'd0);
    expect_eq("R1 runs", 64'(stat_runs), 64'd0);
    expect_eq("R1 total", stat_total, 64'd0);
    expect_eq("R1 avg", 64'(stat_avg), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_eq("R1 rd_stamp", 64'(rd_stamp), 64'd0);
    // R2 timer rate
    n0 = now_us;
    repeat (10 * CPU) @(negedge clk);
    expect_eq("R2 timer advance", 64'(now_us), 64'(n0 + 32'd10));
    expect_eq("R8 avg zero with no runs", 64'(stat_avg), 64'd0);

    // table of capture patterns, including a start inside the lead window
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][2] != 0) do_flush();
      repeat (VEC[i][0]) @(negedge clk);
      do_start();
      write_frame(i);
      check_frame();
      repeat (VEC[i][1]) @(negedge clk);
      do_done();
      check_avg();
    end

    // R7 completion while idle is ignored
    cap_done = 1'b1;
    @(negedge clk);
    cap_done = 1'b0;
    @(negedge clk);
    expect_eq("R7 idle done runs", 64'(stat_runs), 64'(runs_m));
    expect_eq("R7 idle done total", stat_total, total_m);

    // R9 write while idle dropped
    wr_en = 1'b1; wr_addr = '0; wr_data = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0;
    do_start();
    rd_addr = '0;
    @(negedge clk);
    expect_eq("R9 idle write dropped", 64'(rd_data), 64'(mem_m[~sel_m][0]));
    check_frame();

    // R4 start while busy is held until completion
    cap_start = 1'b1;
    @(negedge clk);
    cap_start = 1'b0;
    @(negedge clk);
    expect_eq("R4 bank held while busy", 64'(wr_bank), 64'(sel_m));
    repeat (60) @(negedge clk);
    cap_done = 1'b1;
    model_done(now_us);
    @(negedge clk);
    cap_done = 1'b0;
    expect_eq("R4 pending accepted", 64'(cap_accept), 64'd1);
    model_accept(now_us);
    @(negedge clk);
    expect_eq("R4 bank after pending", 64'(wr_bank), 64'(sel_m));
    expect_eq("R4 busy after pending", 64'(cap_busy), 64'd1);
    expect_eq("R7 runs before pending", 64'(stat_runs), 64'(runs_m));
    check_frame();
    repeat (100) @(negedge clk);
    do_done();
    check_avg();

    // R6 flush then start: stamp reflects the short lead
    do_flush();
    repeat (30) @(negedge clk);
    do_start();
    check_frame();
    repeat (50) @(negedge clk);
    do_done();
    do_start();
    check_frame();
    do_done();
    check_avg();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule